// File: doc/BRIEF.md
# Two-Wire Slave Memory Interface

This block is a serial slave on a two-wire bus (a clock line and an open-drain data line). It gives a bus master read and write access to two storage spaces: a 256-byte memory array and a smaller configuration register space. The four upper bits of the address byte pick the space. The next three bits are compared with three strap pins, and the last bit selects read or write. Both bus lines are sampled with the system clock. The slave pulls the data line low through a single output-enable signal.

Writes arrive either as a single byte or as a page of up to 16 bytes. The page is held in a buffer and committed when STOP is seen. A write cycle of programmable length then follows. During that cycle the slave ignores the bus and sends no acknowledge, so the master polls until the slave answers. Reads come in three forms. A current-address read continues from the internal pointer. A random read loads the pointer with a dummy write and then issues a repeated START. Either form becomes a sequential read when the master acknowledges each byte.

Top module: `twsSlave`

## Requirements
- R1: The address byte is {type[7:4], devAddr[3:1], rw[0]}, where rw=1 means read. Only type MEM_ID (default 4'hA, memory) or CFG_ID (default 4'hB, configuration) is acknowledged. Any other type gets no acknowledge.
- R2: Bit ANY_BIT (7) of configuration register CTRL_ADDR (16) decides how devAddr is matched. When the bit is 0 (its reset value), a byte is acknowledged only if devAddr equals the strap pins. When the bit is 1, a byte with a valid type is acknowledged whatever its devAddr.
- R3: A byte write is the sequence address byte, word address, one data byte, STOP. It stores the data byte at the word address, and a later read returns that byte.
- R4: In a page write, only the low 4 bits of the pointer advance after each data byte. Data bytes past the 16th wrap around and overwrite earlier bytes of the same 16-byte page. Bytes outside the page stay unchanged.
- R5: A STOP that ends a write carrying at least one data byte starts a write cycle of BUSY_CYCLES clocks. During the cycle the data line is never driven, START is ignored and no address byte is acknowledged. After the cycle the slave acknowledges again.
- R6: A STOP that follows a write with no data byte starts no write cycle. The next address byte is acknowledged at once.
- R7: A current-address read returns the byte at the last accessed address plus one.
- R8: A random read is a word-address write followed by a repeated START and a read address byte. It returns the byte at that word address.
- R9: A sequential read keeps sending bytes while the master acknowledges. The pointer advances over all 8 bits and wraps from 255 to 0. A master non-acknowledge ends the read.
- R10: The memory and configuration spaces are separate: the same word address holds independent bytes in each space.
- R11: After reset the data line is released (sdaOe = 0), the configuration space reads zero and the memory reads zero.
- R12: The slave acknowledges an accepted byte by pulling the data line low during the ninth clock. It changes sdaOe only after the clock line has gone low, never while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired level) |
| strapIn | input | 3 | Device address strap pins |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions check on every cycle that the data line stays released during a write cycle and changes only while the bus clock is low. They also check that each page-buffer write advances only the low pointer nibble, that each read advance increments the whole pointer, and that a commit happens only with buffered data and starts the write cycle. Only the bench scenarios can show the end-to-end behaviour: data surviving a write cycle, page overwrites landing at the right offsets, wrap of a sequential read from 255 to 0, strap matching switched by the configuration bit, separation of the two spaces, and acknowledge polling ending after the write cycle.

// File: rtl/twsPkg.sv
package twsPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_WORD, S_WDATA, S_ACK, S_TX, S_MACK, S_WAIT, S_BUSY
  } twsState_t;

  // strobes from control to datapath; cfgSel is a level, the rest pulse one cycle
  typedef struct packed {
    logic              setPtr;
    logic              bufClear;
    logic              bufWrite;
    logic              commit;
    logic              rdAdvance;
    logic              cfgSel;
    logic [BYTE_W-1:0] rxByte;
  } twsStrobe_t;

endpackage

// File: rtl/twsData.sv
module twsData
  import twsPkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int CFG_DEPTH  = 32,
  parameter int CTRL_ADDR  = 16,
  parameter int ANY_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  twsStrobe_t        stb,
  output logic [BYTE_W-1:0] rdByte,
  output logic              anyAddr,
  output logic              hasData,
  output logic [BYTE_W-1:0] ptr
);

  localparam int MEM_DEPTH = 1 << BYTE_W;
  localparam int PW        = $clog2(PAGE_BYTES);
  localparam int CW        = $clog2(CFG_DEPTH);
  localparam int HW        = BYTE_W - PW;

  logic [BYTE_W-1:0]     memArr  [MEM_DEPTH];
  logic [BYTE_W-1:0]     cfgArr  [CFG_DEPTH];
  logic [BYTE_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufVld;
  logic [HW-1:0]         pageHi;
  logic                  bufCfg;

  function automatic logic [BYTE_W-1:0] slotAddr(input logic [HW-1:0] hi, input int idx);
    return {hi, idx[PW-1:0]};
  endfunction

  function automatic logic [CW-1:0] cfgIdx(input logic [BYTE_W-1:0] a);
    return a[CW-1:0];
  endfunction

  assign rdByte  = stb.cfgSel ? cfgArr[cfgIdx(ptr)] : memArr[ptr];
  assign anyAddr = cfgArr[CW'(CTRL_ADDR)][ANY_BIT];
  assign hasData = |bufVld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++)  memArr[i]  <= '0;
      for (int i = 0; i < CFG_DEPTH; i++)  cfgArr[i]  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
      bufVld <= '0;
      pageHi <= '0;
      bufCfg <= 1'b0;
      ptr    <= '0;
    end else begin
      if (stb.setPtr)    ptr <= stb.rxByte;
      if (stb.rdAdvance) ptr <= ptr + BYTE_W'(1);
      if (stb.bufClear)  bufVld <= '0;
      if (stb.bufWrite) begin
        pageBuf[ptr[PW-1:0]] <= stb.rxByte;
        bufVld[ptr[PW-1:0]]  <= 1'b1;
        pageHi               <= ptr[BYTE_W-1:PW];
        bufCfg               <= stb.cfgSel;
        ptr[PW-1:0]          <= ptr[PW-1:0] + PW'(1);
      end
      if (stb.commit) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
          if (bufVld[i]) begin
            if (bufCfg) cfgArr[cfgIdx(slotAddr(pageHi, i))] <= pageBuf[i];
            else        memArr[slotAddr(pageHi, i)]         <= pageBuf[i];
          end
        end
        bufVld <= '0;
      end
    end
  end

endmodule

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter logic [3:0] MEM_ID      = 4'hA,
  parameter logic [3:0] CFG_ID      = 4'hB,
  parameter int         BUSY_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapIn,
  input  logic [BYTE_W-1:0] rdByte,
  input  logic              anyAddr,
  input  logic              hasData,
  output logic              sdaOe,
  output twsStrobe_t        stb,
  output logic              busyFlag
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);

  twsState_t         state, afterAck;
  logic              sclS1, sclS, sclD, sdaS1, sdaS, sdaD;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              wrPend, mAck;
  logic [BW-1:0]     busyCnt;
  logic              sclRise, sclFall, startDet, stopDet, typeOk, devHit, isCfg;

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign isCfg    = rxShift[7:4] == CFG_ID;
  assign typeOk   = (rxShift[7:4] == MEM_ID) || isCfg;
  assign devHit   = typeOk && (anyAddr || rxShift[3:1] == strapIn);
  assign busyFlag = state == S_BUSY;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {sclS1, sclS, sclD, sdaS1, sdaS, sdaD} <= '1;
      state    <= S_IDLE;
      afterAck <= S_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      wrPend   <= 1'b0;
      mAck     <= 1'b0;
      busyCnt  <= '0;
      sdaOe    <= 1'b0;
      stb      <= '0;
    end else begin
      sclS1 <= sclIn; sclS <= sclS1; sclD <= sclS;
      sdaS1 <= sdaIn; sdaS <= sdaS1; sdaD <= sdaS;
      stb.setPtr    <= 1'b0;
      stb.bufClear  <= 1'b0;
      stb.bufWrite  <= 1'b0;
      stb.commit    <= 1'b0;
      stb.rdAdvance <= 1'b0;

      if (state == S_BUSY) begin
        if (busyCnt == '0) state <= S_IDLE;
        else               busyCnt <= busyCnt - BW'(1);
      end else if (startDet) begin
        state  <= S_DEV;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
        wrPend <= 1'b0;
      end else if (stopDet) begin
        sdaOe  <= 1'b0;
        bitCnt <= '0;
        wrPend <= 1'b0;
        if (wrPend && hasData) begin
          stb.commit <= 1'b1;
          busyCnt    <= BW'(BUSY_CYCLES - 1);
          state      <= S_BUSY;
        end else begin
          state <= S_IDLE;
        end
      end else begin
        case (state)
          S_DEV, S_WORD, S_WDATA: begin
            if (sclRise && bitCnt != 4'd8) begin
              rxShift <= {rxShift[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt     <= '0;
              stb.rxByte <= rxShift;
              if (state == S_DEV) begin
                if (devHit) begin
                  sdaOe      <= 1'b1;
                  state      <= S_ACK;
                  afterAck   <= rxShift[0] ? S_TX : S_WORD;
                  stb.cfgSel <= isCfg;
                  stb.bufClear <= ~rxShift[0];
                end else begin
                  state <= S_WAIT;
                end
              end else if (state == S_WORD) begin
                stb.setPtr <= 1'b1;
                sdaOe      <= 1'b1;
                state      <= S_ACK;
                afterAck   <= S_WDATA;
              end else begin
                stb.bufWrite <= 1'b1;
                wrPend       <= 1'b1;
                sdaOe        <= 1'b1;
                state        <= S_ACK;
                afterAck     <= S_WDATA;
              end
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              state  <= afterAck;
              if (afterAck == S_TX) begin
                sdaOe         <= ~rdByte[7];
                txShift       <= {rdByte[6:0], 1'b0};
                stb.rdAdvance <= 1'b1;
              end else begin
                sdaOe <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe <= 1'b0;
                state <= S_MACK;
              end else begin
                sdaOe   <= ~txShift[7];
                txShift <= {txShift[6:0], 1'b0};
              end
            end
          end
          S_MACK: begin
            if (sclRise) begin
              mAck <= ~sdaS;
            end else if (sclFall) begin
              if (mAck) begin
                bitCnt        <= '0;
                sdaOe         <= ~rdByte[7];
                txShift       <= {rdByte[6:0], 1'b0};
                stb.rdAdvance <= 1'b1;
                state         <= S_TX;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/twsSlave.sv
module twsSlave
  import twsPkg::*;
#(
  parameter logic [3:0] MEM_ID      = 4'hA,
  parameter logic [3:0] CFG_ID      = 4'hB,
  parameter int         PAGE_BYTES  = 16,
  parameter int         CFG_DEPTH   = 32,
  parameter int         CTRL_ADDR   = 16,
  parameter int         ANY_BIT     = 7,
  parameter int         BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  output logic       sdaOe
);

  twsStrobe_t        stb;
  logic [BYTE_W-1:0] rdByte;
  logic [BYTE_W-1:0] ptr;
  logic              anyAddr;
  logic              hasData;
  logic              busyFlag;

  twsCtrl #(
    .MEM_ID(MEM_ID), .CFG_ID(CFG_ID), .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .rdByte(rdByte), .anyAddr(anyAddr), .hasData(hasData),
    .sdaOe(sdaOe), .stb(stb), .busyFlag(busyFlag)
  );

  twsData #(
    .PAGE_BYTES(PAGE_BYTES), .CFG_DEPTH(CFG_DEPTH),
    .CTRL_ADDR(CTRL_ADDR), .ANY_BIT(ANY_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdByte(rdByte), .anyAddr(anyAddr), .hasData(hasData), .ptr(ptr)
  );

endmodule

// File: rtl/twsSlaveChk.sv
module twsSlaveChk
  import twsPkg::*;
#(
  parameter int PW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              busyFlag,
  input twsStrobe_t        stb,
  input logic              hasData,
  input logic [BYTE_W-1:0] ptr
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R5: the line is never pulled during the write cycle
  a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> !sdaOe);

  // R5: a commit always opens the write cycle
  a_r5_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> busyFlag);

  // R6: nothing is committed without buffered data
  a_r6_commit_has_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> hasData);

  // R12: output enable holds while the clock line stays high
  a_r12_stable_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && sclIn && $past(sclIn) && $past(sclIn, 2)) |-> $stable(sdaOe));

  // R4: page writes advance only the low nibble
  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufWrite |=> (ptr[BYTE_W-1:PW] == $past(ptr[BYTE_W-1:PW]))
                  && (ptr[PW-1:0] == $past(ptr[PW-1:0]) + PW'(1)));

  // R9: reads advance the full pointer with wrap
  a_r9_read_advance: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdAdvance |=> ptr == $past(ptr) + BYTE_W'(1));

endmodule

bind twsSlave twsSlaveChk uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .busyFlag(busyFlag),
  .stb(stb), .hasData(hasData), .ptr(ptr)
);

// File: tb/tb_twsSlave.sv
module tb_twsSlave;

  localparam int Q = 5;
  localparam int NVEC = 10;
  // {isRead, wordAddr, data}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'h05, 8'h11}, {1'b0, 8'h80, 8'hC3}, {1'b0, 8'h81, 8'h44},
    {1'b0, 8'hFF, 8'h7E}, {1'b0, 8'h00, 8'h5A}, {1'b1, 8'h05, 8'h11},
    {1'b1, 8'h80, 8'hC3}, {1'b1, 8'hFF, 8'h7E}, {1'b1, 8'h00, 8'h5A},
    {1'b1, 8'h81, 8'h44}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclIn = 1'b1;
  logic       mSda = 1'b1;
  logic [2:0] strapIn = 3'b101;
  logic       sdaOe;
  logic       sdaLine;
  logic [7:0] rb [20];
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  assign sdaLine = mSda & ~sdaOe;

  always #5 clk = ~clk;

  twsSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine),
    .strapIn(strapIn), .sdaOe(sdaOe)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    sclIn = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    sclIn = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    sclIn = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      sclIn = 1'b1; waitQ(2);
      sclIn = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    sclIn = 1'b1; waitQ();
    ack = ~sdaLine; waitQ();
    sclIn = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      sclIn = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      sclIn = 1'b0; waitQ();
    end
    mSda = ackIt ? 1'b0 : 1'b1; waitQ();
    sclIn = 1'b1; waitQ(2);
    sclIn = 1'b0; mSda = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] dev, input logic [7:0] addr, input logic [7:0] data);
    logic a;
    busStart();
    sendByte(dev, a);
    sendByte(addr, a);
    sendByte(data, a);
    busStop();
  endtask

  task automatic randRead(input logic [7:0] dev, input logic [7:0] addr, input int n);
    logic a;
    busStart();
    sendByte(dev & 8'hFE, a);
    sendByte(addr, a);
    busStart();
    sendByte(dev | 8'h01, a);
    for (int i = 0; i < n; i++) recvByte(i < n - 1, rb[i]);
    busStop();
  endtask

  task automatic poll(input bit expectBusy, input string req);
    logic a;
    int tries;
    a = 1'b0;
    tries = 0;
    while (!a && tries < 40) begin
      busStart();
      sendByte(8'hAA, a);
      busStop();
      tries++;
    end
    chk(req, int'(a), 1);
    if (expectBusy) chk(req, int'(tries > 1), 1);
    else            chk(req, tries, 1);
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    chk("R11 released after reset", int'(sdaOe), 0);

    // table of byte writes and random reads
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][16]) begin
        randRead(8'hAA, VEC[v][15:8], 1);
        chk("R3 R8 random read", int'(rb[0]), int'(VEC[v][7:0]));
      end else begin
        writeByte(8'hAA, VEC[v][15:8], VEC[v][7:0]);
        poll(1'b1, "R5 write cycle poll");
      end
    end

    // R1: unknown type, R12 ack on word address, R6 no data no busy
    busStart(); sendByte({4'h5, 3'b101, 1'b0}, a); busStop();
    chk("R1 unknown type nack", int'(a), 0);
    busStart(); sendByte(8'hAA, a);
    chk("R12 address ack", int'(a), 1);
    sendByte(8'h10, a);
    chk("R12 word ack", int'(a), 1);
    busStop();
    poll(1'b0, "R6 stop without data");

    // R2: strap matching and its override bit
    busStart(); sendByte({4'hA, 3'b010, 1'b0}, a); busStop();
    chk("R2 strap mismatch nack", int'(a), 0);
    writeByte(8'hBA, 8'h10, 8'h80);
    poll(1'b1, "R5 cfg write poll");
    busStart(); sendByte({4'hA, 3'b010, 1'b0}, a); busStop();
    chk("R2 any address ack", int'(a), 1);
    writeByte(8'hBA, 8'h10, 8'h00);
    poll(1'b1, "R5 cfg restore poll");
    busStart(); sendByte({4'hA, 3'b010, 1'b0}, a); busStop();
    chk("R2 strict again nack", int'(a), 0);

    // R10: separate spaces
    writeByte(8'hBA, 8'h05, 8'h99);
    poll(1'b1, "R5 cfg data poll");
    randRead(8'hBB, 8'h05, 1);
    chk("R10 cfg byte", int'(rb[0]), 8'h99);
    randRead(8'hAA, 8'h05, 1);
    chk("R10 mem byte kept", int'(rb[0]), 8'h11);

    // R4: 18-byte page write from offset E of page 0x30
    busStart();
    sendByte(8'hAA, a);
    sendByte(8'h3E, a);
    for (int k = 0; k < 18; k++) sendByte(8'(8'h20 + k), a);
    busStop();
    poll(1'b1, "R5 page write poll");
    randRead(8'hAA, 8'h2F, 18);
    chk("R4 byte below page", int'(rb[0]), 0);
    for (int off = 0; off < 16; off++) begin
      int e;
      e = (off == 14) ? 8'h30 : (off == 15) ? 8'h31 : 8'h22 + off;
      chk("R4 page wrap data", int'(rb[1 + off]), e);
    end
    chk("R4 byte above page", int'(rb[17]), 0);

    // R7: current-address read
    randRead(8'hAA, 8'h80, 1);
    chk("R8 random read", int'(rb[0]), 8'hC3);
    busStart(); sendByte(8'hAB, a); recvByte(1'b0, b); busStop();
    chk("R7 current address", int'(b), 8'h44);

    // R9: sequential read wraps 255 to 0
    randRead(8'hAA, 8'hFF, 2);
    chk("R9 last byte", int'(rb[0]), 8'h7E);
    chk("R9 wrapped byte", int'(rb[1]), 8'h5A);
    busStart(); sendByte(8'hAB, a); recvByte(1'b0, b); busStop();
    chk("R9 pointer after wrap", int'(b), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule